// File: doc/BRIEF.md
# Dual-Source Prescaled Watchdog Timer

This block is a watchdog that issues a one-cycle device reset pulse when software stops clearing it in time. Its count is driven by one of two tick sources, picked by a static configuration bit: a slow oscillator tick that arrives as a single-cycle strobe in the system clock domain, or the instruction clock, which is the system clock divided by four.

The chosen tick goes through a fixed 256:1 divider built from eight counter stages. It then goes through a power-of-two prescaler whose ratio comes from a 3-bit select register, and finally into a small overflow counter. When that counter overflows, the block raises the reset output for one cycle and returns every counting stage to zero. Software restarts the whole chain with a clear strobe. A configuration enable switches the watchdog off as a whole: while it is off, clears and select writes do nothing and no reset can occur.

Top module: `wdog_dual_src`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `rst_out` is low, and the select register comes out of reset holding 7 (prescale 1:128).
- R2: With `cfg_src` = 0 (oscillator tick) and `osc_tick` high every cycle, the first `rst_out` pulse comes at system clock edge 3 + 256·2^(sel+FIN_W), counted from the clock edge that samples the clear.
- R3: With `cfg_src` = 1 (instruction clock), `osc_tick` is ignored and ticks arrive every fourth system clock, so the first pulse comes at edge 3 + 1024·2^(sel+FIN_W) after the clear.
- R4: A write with `ws_wr_en` high and the watchdog enabled loads `ws_wr_data[2:0]` into the select register. The prescale ratio is 2^sel (1:1 to 1:128), and the new value takes effect from the next clear.
- R5: A `wdt_clr` strobe while enabled returns the divider, the prescaler and the overflow counter to zero, so the next pulse comes one full interval after the clear. No pulse appears in the cycle after a clear.
- R6: `rst_out` is high for exactly one cycle. Every stage restarts from zero on the same edge, so the pulses repeat with the same interval.
- R7: While `cfg_en` is low, `rst_out` stays low, `wdt_clr` has no effect, and select writes are discarded. After re-enabling, the interval still follows the earlier select value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Configuration enable of the watchdog |
| cfg_src | input | 1 | Tick source: 0 oscillator tick, 1 instruction clock |
| osc_tick | input | 1 | Oscillator tick strobe, synchronous to clk |
| ws_wr_en | input | 1 | Select register write strobe |
| ws_wr_data | input | SEL_W | Prescale select value |
| wdt_clr | input | 1 | Software clear strobe |
| rst_out | output | 1 | One-cycle device reset pulse |

## Verification
The hardest condition to reach is the full 1:128 timeout, since at the default overflow width it takes millions of cycles. The bench builds the block with a one-bit overflow counter and holds the oscillator tick high on every cycle, which brings the longest interval down to about 65 thousand cycles while the divider and prescaler timing stay exactly as designed. The interaction between the disable and a pending select write is exercised by writing a different select while disabled, then re-enabling and measuring the interval against the value that was held before.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic {
    SRC_OSC  = 1'b0,
    SRC_ICLK = 1'b1
  } tick_src_e;

endpackage

// File: rtl/wdog_tick_src.sv
module wdog_tick_src
  import wdog_pkg::*;
#(
  parameter int ICLK_DIV_W = 2
) (
  input  logic      clk,
  input  logic      clr,
  input  tick_src_e src_sel,
  input  logic      osc_tick,
  output logic      tick_o
);

  logic [ICLK_DIV_W-1:0] phase_q;
  localparam logic [ICLK_DIV_W-1:0] PH_ONE = 1;

  always_ff @(posedge clk) begin
    if (clr) begin
      phase_q <= '0;
      tick_o  <= 1'b0;
    end else begin
      phase_q <= phase_q + PH_ONE;
      if (src_sel == SRC_OSC) tick_o <= osc_tick;
      else                    tick_o <= &phase_q;
    end
  end

endmodule

// File: rtl/wdog_count_stage.sv
module wdog_count_stage #(
  parameter int W = 8
) (
  input  logic clk,
  input  logic clr,
  input  logic tick_i,
  output logic carry_o
);

  localparam logic [W-1:0] CNT_ONE = 1;
  logic [W-1:0] cnt_q;

  // Carry fires on the tick that wraps the stage back to zero.
  assign carry_o = tick_i & (&cnt_q);

  always_ff @(posedge clk) begin
    if (clr)         cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_q + CNT_ONE;
  end

endmodule

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             tick_i,
  output logic             tick_o
);

  localparam int CNT_W = (1 << SEL_W) - 1;
  localparam logic [CNT_W-1:0] CNT_ONE = 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;
  logic             tap;

  // Mask has sel_i low bits set; the tap fires every 2^sel_i input ticks.
  always_comb begin
    for (int b = 0; b < CNT_W; b++) mask[b] = (b < int'(sel_i));
  end

  assign tap = tick_i & ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      if (tick_i) cnt_q <= cnt_q + CNT_ONE;
      tick_o <= tap;
    end
  end

endmodule

// File: rtl/wdog_dual_src.sv
module wdog_dual_src
  import wdog_pkg::*;
#(
  parameter int          FIX_STAGES = 8,
  parameter int          SEL_W      = 3,
  parameter int          FIN_W      = 4,
  parameter int          ICLK_DIV_W = 2,
  parameter logic [SEL_W-1:0] SEL_RST = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_en,
  input  logic             cfg_src,
  input  logic             osc_tick,
  input  logic             ws_wr_en,
  input  logic [SEL_W-1:0] ws_wr_data,
  input  logic             wdt_clr,
  output logic             rst_out
);

  logic             clr_all;
  logic             src_tick;
  logic             fix_carry;
  logic             fdiv_tick;
  logic             pre_tick;
  logic             fin_carry;
  logic [SEL_W-1:0] sel_q;
  tick_src_e        src_sel;

  assign src_sel = tick_src_e'(cfg_src);
  assign clr_all = rst | ~cfg_en | wdt_clr | fin_carry;

  always_ff @(posedge clk) begin
    if (rst)                      sel_q <= SEL_RST;
    else if (cfg_en && ws_wr_en)  sel_q <= ws_wr_data;
  end

  wdog_tick_src #(.ICLK_DIV_W(ICLK_DIV_W)) u_src (
    .clk(clk), .clr(clr_all), .src_sel(src_sel),
    .osc_tick(osc_tick), .tick_o(src_tick)
  );

  wdog_count_stage #(.W(FIX_STAGES)) u_fix (
    .clk(clk), .clr(clr_all), .tick_i(src_tick), .carry_o(fix_carry)
  );

  always_ff @(posedge clk) begin
    if (clr_all) fdiv_tick <= 1'b0;
    else         fdiv_tick <= fix_carry;
  end

  wdog_prescaler #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .clr(clr_all), .sel_i(sel_q),
    .tick_i(fdiv_tick), .tick_o(pre_tick)
  );

  wdog_count_stage #(.W(FIN_W)) u_fin (
    .clk(clk), .clr(clr_all), .tick_i(pre_tick), .carry_o(fin_carry)
  );

  always_ff @(posedge clk) begin
    if (rst) rst_out <= 1'b0;
    else     rst_out <= cfg_en & ~wdt_clr & fin_carry;
  end

endmodule

// File: rtl/wdog_dual_src_chk.sv
module wdog_dual_src_chk #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_en,
  input logic             wdt_clr,
  input logic             rst_out,
  input logic [SEL_W-1:0] sel_q,
  input logic             fdiv_tick,
  input logic             pre_tick,
  input logic             fin_carry
);

  p_pre_from_fixed_r4: assert property (@(posedge clk) disable iff (rst)
    pre_tick |-> $past(fdiv_tick));

  p_clear_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (wdt_clr && cfg_en) |=> !rst_out);

  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    rst_out |=> !rst_out);

  p_overflow_cause_r6: assert property (@(posedge clk) disable iff (rst)
    rst_out |-> $past(fin_carry));

  p_disabled_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> !rst_out);

  p_sel_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> $stable(sel_q));

endmodule

bind wdog_dual_src wdog_dual_src_chk #(.SEL_W(SEL_W)) chk_i (
  .clk(clk), .rst(rst), .cfg_en(cfg_en), .wdt_clr(wdt_clr),
  .rst_out(rst_out), .sel_q(sel_q), .fdiv_tick(fdiv_tick),
  .pre_tick(pre_tick), .fin_carry(fin_carry)
);

// File: tb/wdog_dual_src_tb.sv
module wdog_dual_src_tb_top;

  localparam int FIN_W = 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_en = 1'b1;
  logic       cfg_src = 1'b0;
  logic       osc_tick = 1'b1;
  logic       ws_wr_en = 1'b0;
  logic [2:0] ws_wr_data = 3'd0;
  logic       wdt_clr = 1'b0;
  logic       rst_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  wdog_dual_src #(.FIN_W(FIN_W)) dut_i (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_src(cfg_src),
    .osc_tick(osc_tick), .ws_wr_en(ws_wr_en), .ws_wr_data(ws_wr_data),
    .wdt_clr(wdt_clr), .rst_out(rst_out)
  );

  // {source, select, expected edge of first pulse after the clear}
  localparam logic [35:0] VEC [8] = '{
    {1'b0, 3'd0, 32'd515},
    {1'b0, 3'd1, 32'd1027},
    {1'b0, 3'd2, 32'd2051},
    {1'b0, 3'd3, 32'd4099},
    {1'b0, 3'd4, 32'd8195},
    {1'b1, 3'd0, 32'd2051},
    {1'b1, 3'd1, 32'd4099},
    {1'b1, 3'd2, 32'd8195}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FIL%s %s: actual %0d expected %0d", "", req, act, exp);
    end
  endtask

  task automatic write_sel(input logic [2:0] v);
    @(negedge clk); ws_wr_en = 1'b1; ws_wr_data = v;
    @(negedge clk); ws_wr_en = 1'b0;
  endtask

  // Clear, then record the edge of the first and second pulses.
  task automatic clear_measure(input int exp, input bit periodic, input string req);
    int first = -1;
    int second = -1;
    int highs = 0;
    int span = periodic ? 2 * exp + 2 : exp + 4;
    @(negedge clk); wdt_clr = 1'b1;
    @(negedge clk); wdt_clr = 1'b0;
    for (int i = 1; i <= span; i++) begin
      @(negedge clk);
      if (rst_out) begin
        if (first < 0) first = i;
        else if (second < 0) second = i;
        if (i <= exp + 4) highs++;
      end
    end
    check(first == exp, req, first, exp);
    check(highs == 1, "R6 pulse width", highs, 1);
    if (periodic) check(second == 2 * exp, "R6 repeat", second, 2 * exp);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rst_out == 1'b0, "R1 reset low", int'(rst_out), 0);
    rst = 1'b0;
    @(negedge clk);
    check(rst_out == 1'b0, "R1 after reset", int'(rst_out), 0);

    // R1: default select 7 gives 1:128
    clear_measure(3 + 256 * 256, 1'b0, "R1 default sel");

    // Table walk: R2 oscillator, R3 instruction clock, R4 select ratio
    for (int v = 0; v < 8; v++) begin
      cfg_src = VEC[v][35];
      osc_tick = 1'b1;
      write_sel(VEC[v][34:32]);
      clear_measure(int'(VEC[v][31:0]), 1'b1,
                    VEC[v][35] ? "R3 iclk interval" : "R2 osc interval");
    end

    // R3: osc_tick low must not stall the instruction clock path
    cfg_src = 1'b1; osc_tick = 1'b0;
    write_sel(3'd0);
    clear_measure(2051, 1'b0, "R3 osc ignored");
    cfg_src = 1'b0; osc_tick = 1'b1;

    // R5: clear in the middle restarts the interval
    begin
      int early = 0;
      @(negedge clk); wdt_clr = 1'b1;
      @(negedge clk); wdt_clr = 1'b0;
      for (int i = 0; i < 400; i++) begin
        @(negedge clk);
        if (rst_out) early++;
      end
      check(early == 0, "R5 no early pulse", early, 0);
      clear_measure(515, 1'b0, "R5 restart after clear");
    end

    // R7: disabled watchdog ignores clear and select write, never pulses
    begin
      int seen = 0;
      @(negedge clk); cfg_en = 1'b0;
      write_sel(3'd3);
      @(negedge clk); wdt_clr = 1'b1;
      @(negedge clk); wdt_clr = 1'b0;
      for (int i = 0; i < 2000; i++) begin
        @(negedge clk);
        if (rst_out) seen++;
      end
      check(seen == 0, "R7 disabled no pulse", seen, 0);
      @(negedge clk); cfg_en = 1'b1;
      clear_measure(515, 1'b0, "R7 write ignored");
    end

    done = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule